// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block chooses which of several DMA request lines owns the next transfer on a single shared bus master. Each channel has a request line and an enable bit. Requests from disabled channels are removed before arbitration. The transfer sequencer strobes `sample_i` once per transfer cycle. On that strobe the winning channel is captured into a registered one-hot grant, which then stays fixed for the whole transfer. A combinational flag reports whether any enabled channel is requesting, so the sequencer can decide whether to ask for the bus.

Two priority schemes are available, and `rotate_i` selects between them. In the fixed scheme the lowest channel index always wins. In the rotating scheme a pointer names the channel with the highest priority, and the others follow in ascending index order with wrap-around. The pointer moves only when the sequencer reports a completed transfer cycle through `done_i`/`done_idx_i`. The channel that was just serviced then becomes the lowest priority. Because the grant is re-evaluated at every sample, a higher-priority request takes over from a burst on a lower channel at the next cycle, with no idle cycle in between.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `any_req_o` is high exactly when some channel has both `req_i` and `chan_en_i` set, in the same cycle with no register delay.
- R2: A channel whose `chan_en_i` bit is 0 is never granted, whatever its `req_i`.
- R3: `grant_o` is registered, is all zeros after reset, and changes only on a clock edge where `sample_i` is 1; otherwise it holds its value.
- R4: `grant_o` is one-hot or zero. A sample with no enabled request loads all zeros.
- R5: With `rotate_i` = 0, the enabled requesting channel with the lowest index wins (bit n of `grant_o` is channel n).
- R6: After reset the rotation pointer is channel 0, so in rotating mode channel 0 has the highest priority until the first completed cycle.
- R7: With `rotate_i` = 1, a `done_i` pulse loads the pointer with (`done_idx_i` + 1) mod NCH. The serviced channel becomes the lowest priority, and the order runs upward from the pointer with wrap-around.
- R8: The pointer never moves on samples or requests alone; only `done_i` moves it.
- R9: A `done_i` pulse while `rotate_i` = 0 leaves the pointer unchanged.
- R10: When `sample_i` and `done_i` share an edge, the sample uses the pointer value from before that edge.
- R11: Back-to-back samples may grant different channels, so a higher-priority request overrides a lower-priority burst on the very next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NCH | Per-channel transfer request |
| chan_en_i | input | NCH | Per-channel enable mask |
| rotate_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| sample_i | input | 1 | Strobe from the sequencer: capture a new grant |
| done_i | input | 1 | Pulse: a transfer cycle has completed |
| done_idx_i | input | CW | Index of the channel that was just serviced |
| grant_o | output | NCH | Registered one-hot grant |
| any_req_o | output | 1 | OR of the enabled requests |

## Verification
The arbiter is driven with all channels requesting, sparse request sets, and requests masked by disabled channels. These patterns separate a correct priority order from one that ignores the enable mask or favours the wrong end. In rotating mode, completion pulses are placed on different channels, and one of them lands on the same edge as a sample. These cases tell apart pointer wrap-around, the order of the pointer update relative to sampling, and rotation triggered by the wrong event. Fixed-mode completion pulses, repeated samples with no completion, and a lower channel bursting while a higher one arrives show that the pointer is left alone when it should be, and that a channel switch costs no extra cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dma_arb_ptr.sv
module dma_arb_ptr #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 2
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  logic          rotate,
  input  logic          done,
  input  logic [CW-1:0] done_idx,
  output logic [CW-1:0] top_q
);

  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic          ptr_en;
  logic [CW-1:0] ptr_d;

  always_comb begin
    ptr_en = done && rotate;
    ptr_d  = (done_idx == LAST) ? '0 : done_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      top_q <= '0;
    end else if (ptr_en) begin
      top_q <= ptr_d;
    end
  end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 2
) (
  input  logic [NCH-1:0] cand,
  input  logic [CW-1:0]  top,
  output logic [NCH-1:0] win
);

  always_comb begin
    logic found;
    win   = '0;
    found = 1'b0;
    for (int unsigned k = 0; k < NCH; k++) begin
      int unsigned pos;
      pos = (int'(top) + k) % NCH;
      if (!found && cand[pos]) begin
        win[pos] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = idx_width(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] chan_en_i,
  input  logic           rotate_i,
  input  logic           sample_i,
  input  logic           done_i,
  input  logic [CW-1:0]  done_idx_i,
  output logic [NCH-1:0] grant_o,
  output logic           any_req_o
);

  logic [1:0]     rst_sync_q;
  logic           rst_q_n;
  logic [NCH-1:0] cand;
  logic [CW-1:0]  top_q;
  logic [CW-1:0]  eff_top;
  logic [NCH-1:0] win;
  logic [NCH-1:0] grant_q;
  logic [NCH-1:0] grant_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  for (genvar g = 0; g < NCH; g++) begin : g_mask
    assign cand[g] = req_i[g] & chan_en_i[g];
  end

  assign any_req_o = |cand;

  dma_arb_ptr #(.NCH(NCH), .CW(CW)) u_ptr (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .rotate   (rotate_i),
    .done     (done_i),
    .done_idx (done_idx_i),
    .top_q    (top_q)
  );

  assign eff_top = rotate_i ? top_q : '0;

  dma_arb_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .cand (cand),
    .top  (eff_top),
    .win  (win)
  );

  always_comb begin
    grant_d = sample_i ? win : grant_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      grant_q <= '0;
    end else begin
      grant_q <= grant_d;
    end
  end

  assign grant_o = grant_q;

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 2
) (
  input logic           clk,
  input logic           rst_q_n,
  input logic [NCH-1:0] req_i,
  input logic [NCH-1:0] chan_en_i,
  input logic           rotate_i,
  input logic           sample_i,
  input logic [NCH-1:0] grant_o,
  input logic           any_req_o
);

  a_r4_onehot_grant: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(grant_o));

  a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_q_n)
    sample_i |=> ((grant_o & ~($past(req_i) & $past(chan_en_i))) == '0));

  a_r3_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sample_i |=> $stable(grant_o));

  a_r4_empty_sample_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sample_i && !any_req_o) |=> (grant_o == '0));

  a_r1_busy_sample_grants: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sample_i && any_req_o) |=> (grant_o != '0));

  a_r5_fixed_ch0_wins: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sample_i && !rotate_i && req_i[0] && chan_en_i[0]) |=> grant_o[0]);

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .req_i     (req_i),
  .chan_en_i (chan_en_i),
  .rotate_i  (rotate_i),
  .sample_i  (sample_i),
  .grant_o   (grant_o),
  .any_req_o (any_req_o)
);

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 2;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] req_i;
  logic [NCH-1:0] chan_en_i;
  logic           rotate_i;
  logic           sample_i;
  logic           done_i;
  logic [CW-1:0]  done_idx_i;
  logic [NCH-1:0] grant_o;
  logic           any_req_o;

  int checks;
  int errors;
  int ref_ptr;
  logic [NCH-1:0] ref_grant;

  dma_prio_arbiter #(.NCH(NCH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .chan_en_i  (chan_en_i),
    .rotate_i   (rotate_i),
    .sample_i   (sample_i),
    .done_i     (done_i),
    .done_idx_i (done_idx_i),
    .grant_o    (grant_o),
    .any_req_o  (any_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [NCH-1:0] ref_pick(input logic [NCH-1:0] r, input logic [NCH-1:0] e,
                                              input logic rot, input int p);
    int start;
    ref_pick = '0;
    start = rot ? p : 0;
    for (int k = 0; k < NCH; k++) begin
      int c;
      c = (start + k) % NCH;
      if (r[c] && e[c]) begin
        ref_pick[c] = 1'b1;
        return ref_pick;
      end
    end
  endfunction

  task automatic check_grant(input string tag);
    checks++;
    if (grant_o !== ref_grant) begin
      errors++;
      $display("FAIL %s grant actual=%b expected=%b", tag, grant_o, ref_grant);
    end
  endtask

  // Drive at a negedge, check any_req_o, clock once, update the model, check at the next negedge.
  task automatic step(input logic [NCH-1:0] r, input logic [NCH-1:0] e, input logic rot,
                      input logic smp, input logic dn, input int didx, input string tag);
    logic exp_any;
    req_i      = r;
    chan_en_i  = e;
    rotate_i   = rot;
    sample_i   = smp;
    done_i     = dn;
    done_idx_i = CW'(didx);
    #1;
    exp_any = |(r & e);
    checks++;
    if (any_req_o !== exp_any) begin
      errors++;
      $display("FAIL R1 any_req actual=%b expected=%b", any_req_o, exp_any);
    end
    @(posedge clk);
    if (smp) ref_grant = ref_pick(r, e, rot, ref_ptr);
    if (dn && rot) ref_ptr = (didx + 1) % NCH;
    @(negedge clk);
    check_grant(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; ref_ptr = 0; ref_grant = '0;
    rst_n = 1'b0; req_i = '0; chan_en_i = '0; rotate_i = 0;
    sample_i = 0; done_i = 0; done_idx_i = '0;
    repeat (3) @(negedge clk);
    check_grant("R3 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_grant("R3 after reset");

    // R1: enable mask gates the any-request flag
    step(4'b0100, 4'b1111, 0, 0, 0, 0, "R1");
    step(4'b0100, 4'b1011, 0, 0, 0, 0, "R1 masked");
    // R5: fixed order
    step(4'b1111, 4'b1111, 0, 1, 0, 0, "R5 all");
    step(4'b1110, 4'b1111, 0, 1, 0, 0, "R5 ch1");
    step(4'b1100, 4'b1111, 0, 1, 0, 0, "R5 ch2");
    // R2: disabled channel 0 skipped
    step(4'b0011, 4'b1110, 0, 1, 0, 0, "R2");
    step(4'b0001, 4'b1110, 0, 1, 0, 0, "R2 lone disabled");
    step(4'b0100, 4'b1111, 0, 1, 0, 0, "R2 setup");
    // R3: hold without sample
    step(4'b0001, 4'b1111, 0, 0, 0, 0, "R3 hold");
    step(4'b0000, 4'b1111, 0, 0, 0, 0, "R3 hold idle");
    // R4: empty sample clears
    step(4'b0000, 4'b1111, 0, 1, 0, 0, "R4");
    // R9: fixed-mode done does not move pointer; R6: pointer still 0
    step(4'b0000, 4'b1111, 0, 0, 1, 2, "R9");
    step(4'b1111, 4'b1111, 1, 1, 0, 0, "R6 R9");
    // R7: rotation after completion
    step(4'b1111, 4'b1111, 1, 0, 1, 0, "R7 done0");
    step(4'b1111, 4'b1111, 1, 1, 0, 0, "R7 ch1 top");
    step(4'b0011, 4'b1111, 1, 0, 1, 1, "R7 done1");
    step(4'b0011, 4'b1111, 1, 1, 0, 0, "R7 wrap");
    step(4'b1111, 4'b1111, 1, 0, 1, 3, "R7 done3");
    step(4'b1110, 4'b1111, 1, 1, 0, 0, "R7 wrap to 0");
    // R8: samples alone do not rotate
    step(4'b1111, 4'b1111, 1, 1, 0, 0, "R8 a");
    step(4'b1111, 4'b1111, 1, 1, 0, 0, "R8 b");
    step(4'b1100, 4'b1111, 1, 1, 0, 0, "R8 c");
    // R10: sample and done on the same edge
    step(4'b0000, 4'b1111, 1, 0, 1, 1, "R10 setup");
    step(4'b1111, 4'b1111, 1, 1, 1, 0, "R10 same edge");
    step(4'b1111, 4'b1111, 1, 1, 0, 0, "R10 after");
    // R11: higher request overrides a lower burst next sample
    step(4'b1000, 4'b1111, 0, 1, 0, 0, "R11 burst ch3");
    step(4'b1000, 4'b1111, 0, 1, 0, 0, "R11 burst ch3 again");
    step(4'b1001, 4'b1111, 0, 1, 0, 0, "R11 ch0 overrides");
    step(4'b1000, 4'b1111, 0, 1, 0, 0, "R11 back to ch3");
    // R2 in rotating mode: masked top channel
    step(4'b1111, 4'b1111, 1, 0, 1, 1, "R2 setup rot");
    step(4'b1111, 4'b1011, 1, 1, 0, 0, "R2 rot masked");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule